// File: doc/BRIEF.md
# Oversampling UART Receiver

This block turns an asynchronous serial line into received words. A single-cycle sample pulse arrives sixteen times per bit period. Each frame's start bit must match a fixed thirteen-sample shape before the receiver commits to it. Every data bit and the stop bit are then decided by a majority vote over three samples taken in the middle of the bit. The 8 or 9 bits of the word arrive least significant bit first and are moved into a holding register when the stop bit has been judged.

Software or a downstream consumer watches a data-ready flag, reads the word and pulses a read strobe to free the register. Four sticky error flags report the outcome of each frame:

- line noise,
- a low stop bit,
- a parity mismatch,
- a word lost because the register was still occupied.

A flow-control output tells the far end to pause while the register is full.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rxne`, `rx_data` and all four error flags are 0, and `rts_n` is 0.
- R2: A frame is accepted only when thirteen consecutive line samples match 1,1,1,0,X,0,X,0,X,0,0,0,0 (oldest first, X = either value). The X positions are the 2nd, 4th and 6th samples of the start bit. Any other shape produces no word and sets no flag.
- R3: Each data bit and the stop bit take the majority of samples 8, 9 and 10 of that bit. If the three disagree anywhere in the frame, `err_noise` is set for that frame.
- R4: The word is shifted in least significant bit first and appears on `rx_data`. It has 9 bits when `cfg_nine_bit` is 1. It has 8 bits when `cfg_nine_bit` is 0, and then `rx_data[8]` reads 0.
- R5: With `cfg_par_en` set, the last received bit is parity. `err_parity` is set when the count of ones over the whole word, parity bit included, is odd while `cfg_par_odd` is 0, or even while `cfg_par_odd` is 1.
- R6: A stop bit decided low sets `err_frame`, and the frame's word is still loaded into `rx_data`.
- R7: At the end of a frame, with `rxne` clear, the word is loaded and `rxne` is set. `err_noise`, `err_frame` and `err_parity` rise in that same cycle.
- R8: If `rxne` is still 1 when a frame ends, `err_overrun` is set. `rx_data` keeps its old value, `rxne` stays 1, and the new word is dropped.
- R9: With `cfg_rts_en` at 1, `rts_n` equals `rxne`: low while the register is free and high while it is full. With `cfg_rts_en` at 0, `rts_n` is 0.
- R10: Driving `rx_enable` low during a frame aborts the frame. No word is loaded and no flag is set.
- R11: A `rd_strobe` pulse clears `rxne` and leaves the error flags alone. A `clr_strobe` pulse clears all four error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle pulse, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high, asynchronous |
| rx_enable | input | 1 | Receiver enable; low aborts and holds idle |
| cfg_nine_bit | input | 1 | 1: 9-bit words, 0: 8-bit words |
| cfg_par_en | input | 1 | Last word bit is parity |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_rts_en | input | 1 | Enable flow-control output |
| rd_strobe | input | 1 | Consumer has taken the word |
| clr_strobe | input | 1 | Clear the error flags |
| rx_data | output | 9 | Received word |
| rxne | output | 1 | Word waiting in the register |
| err_noise | output | 1 | Sample disagreement seen |
| err_frame | output | 1 | Stop bit was low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | A word was dropped |
| rts_n | output | 1 | High asks the sender to pause |

## Verification
The properties assume the following about the inputs:

- `sample_en` is a single-cycle pulse from a steady divider.
- The configuration inputs stay still while a frame is on the line.
- A read and a frame end are not expected to line up on purpose.

The stimulus follows these assumptions. It drives the line in whole-sample units of four clocks, matching a fixed one-in-four sample pulse. It changes configuration only between frames, while the line is idle. It issues strobes only at times when no frame is about to end.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int PHW        = $clog2(OVERSAMPLE);
    localparam int WORD_MAX   = 9;
    localparam int IDXW       = $clog2(WORD_MAX);
    localparam int WIN_LEN    = 13;

    // sample phases (0-based) used by the voter; 8th, 9th, 10th sample
    localparam logic [PHW-1:0] PH_VOTE_A = PHW'(7);
    localparam logic [PHW-1:0] PH_VOTE_B = PHW'(8);
    localparam logic [PHW-1:0] PH_VOTE_C = PHW'(9);
    localparam logic [PHW-1:0] PH_LAST   = PHW'(OVERSAMPLE - 1);
    // phase of the sample that follows a matched start window
    localparam logic [PHW-1:0] PH_AFTER_START = PHW'(10);

    // window bit 12 is oldest; ones in the mask are compared
    localparam logic [WIN_LEN-1:0] START_MASK = 13'b1111010101111;
    localparam logic [WIN_LEN-1:0] START_VAL  = 13'b1110000000000;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_MAX-1:0] word;
        logic                noise;
        logic                frame_err;
        logic                par_err;
    } rx_result_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

    function automatic logic start_match(input logic [WIN_LEN-1:0] w);
        return (w & START_MASK) == START_VAL;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic       enable,
    input  logic       nine_bit,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       done,
    output rx_result_t res
);
    rx_state_e            state;
    logic [WIN_LEN-1:0]   win;
    logic [WIN_LEN-1:0]   win_next;
    logic [PHW-1:0]       ph;
    logic [IDXW-1:0]      idx;
    logic [WORD_MAX-1:0]  shreg;
    logic                 smp_a, smp_b;
    logic                 noise_acc;
    logic [IDXW-1:0]      last_idx;
    logic                 vote;

    assign win_next = {win[WIN_LEN-2:0], line};
    assign last_idx = nine_bit ? IDXW'(WORD_MAX - 1) : IDXW'(WORD_MAX - 2);
    assign vote     = maj3(smp_a, smp_b, line);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            win       <= '0;
            ph        <= '0;
            idx       <= '0;
            shreg     <= '0;
            smp_a     <= 1'b0;
            smp_b     <= 1'b0;
            noise_acc <= 1'b0;
        end else if (!enable) begin
            state <= RX_IDLE;
            win   <= '0;
        end else if (tick) begin
            win <= win_next;
            ph  <= ph + 1'b1;
            if (state == RX_DATA || state == RX_STOP) begin
                if (ph == PH_VOTE_A) smp_a <= line;
                if (ph == PH_VOTE_B) smp_b <= line;
            end
            case (state)
                RX_IDLE: begin
                    if (start_match(win_next)) begin
                        state     <= RX_START;
                        ph        <= PH_AFTER_START;
                        idx       <= '0;
                        shreg     <= '0;
                        noise_acc <= 1'b0;
                    end
                end
                RX_START: begin
                    if (ph == PH_LAST) state <= RX_DATA;
                end
                RX_DATA: begin
                    if (ph == PH_VOTE_C) begin
                        shreg[idx] <= vote;
                        if (split3(smp_a, smp_b, line)) noise_acc <= 1'b1;
                    end
                    if (ph == PH_LAST) begin
                        if (idx == last_idx) state <= RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (ph == PH_VOTE_C) begin
                        state <= RX_IDLE;
                        win   <= '0;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign done          = enable & tick & (state == RX_STOP) & (ph == PH_VOTE_C);
    assign res.word      = shreg;
    assign res.noise     = noise_acc | split3(smp_a, smp_b, line);
    assign res.frame_err = ~vote;
    assign res.par_err   = par_en & ((^shreg) ^ par_odd);
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done,
    input  rx_result_t          res,
    input  logic                rd,
    input  logic                clr,
    input  logic                rts_en,
    output logic [WORD_MAX-1:0] data,
    output logic                full,
    output logic                f_noise,
    output logic                f_frame,
    output logic                f_parity,
    output logic                f_overrun,
    output logic                rts_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data      <= '0;
            full      <= 1'b0;
            f_noise   <= 1'b0;
            f_frame   <= 1'b0;
            f_parity  <= 1'b0;
            f_overrun <= 1'b0;
        end else begin
            if (rd) full <= 1'b0;
            if (clr) begin
                f_noise   <= 1'b0;
                f_frame   <= 1'b0;
                f_parity  <= 1'b0;
                f_overrun <= 1'b0;
            end
            if (done) begin
                if (full) begin
                    f_overrun <= 1'b1;
                end else begin
                    data <= res.word;
                    full <= 1'b1;
                    if (res.noise)     f_noise  <= 1'b1;
                    if (res.frame_err) f_frame  <= 1'b1;
                    if (res.par_err)   f_parity <= 1'b1;
                end
            end
        end
    end

    assign rts_n = rts_en & full;
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_en,
    input  logic                rx_in,
    input  logic                rx_enable,
    input  logic                cfg_nine_bit,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_rts_en,
    input  logic                rd_strobe,
    input  logic                clr_strobe,
    output logic [WORD_MAX-1:0] rx_data,
    output logic                rxne,
    output logic                err_noise,
    output logic                err_frame,
    output logic                err_parity,
    output logic                err_overrun,
    output logic                rts_n
);
    logic       line_s;
    logic       frame_done;
    rx_result_t frame_res;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_in),
        .q   (line_s)
    );

    rx_bit_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_en),
        .line     (line_s),
        .enable   (rx_enable),
        .nine_bit (cfg_nine_bit),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .done     (frame_done),
        .res      (frame_res)
    );

    rx_hold_reg u_hold (
        .clk       (clk),
        .rst       (rst),
        .done      (frame_done),
        .res       (frame_res),
        .rd        (rd_strobe),
        .clr       (clr_strobe),
        .rts_en    (cfg_rts_en),
        .data      (rx_data),
        .full      (rxne),
        .f_noise   (err_noise),
        .f_frame   (err_frame),
        .f_parity  (err_parity),
        .f_overrun (err_overrun),
        .rts_n     (rts_n)
    );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_enable,
    input logic       cfg_rts_en,
    input logic       rd_strobe,
    input logic       clr_strobe,
    input logic [8:0] rx_data,
    input logic       rxne,
    input logic       err_noise,
    input logic       err_frame,
    input logic       err_parity,
    input logic       err_overrun,
    input logic       rts_n
);
    // R7: status flags only rise together with the data-ready flag
    assert_flags_with_rxne_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_noise) || $rose(err_frame) || $rose(err_parity)) |-> $rose(rxne));

    // R8: a held word is not replaced until it has been read
    assert_data_held_R8: assert property (@(posedge clk) disable iff (rst)
        (rxne && !rd_strobe) |=> $stable(rx_data));

    // R8: overrun only arises while a word was already waiting
    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> $past(rxne));

    // R9: a full register held without a read keeps pause requested
    assert_rts_full_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_rts_en && rxne && !rd_strobe) |=> rts_n);

    // R10: a disabled receiver never produces a word
    assert_disabled_no_word_R10: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !$rose(rxne));

    // R11: a read empties the register
    assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rxne) |=> !rxne);

    // R11: clearing while disabled empties every error flag
    assert_clear_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (clr_strobe && !rx_enable) |=> !(err_noise || err_frame || err_parity || err_overrun));
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_enable   (rx_enable),
    .cfg_rts_en  (cfg_rts_en),
    .rd_strobe   (rd_strobe),
    .clr_strobe  (clr_strobe),
    .rx_data     (rx_data),
    .rxne        (rxne),
    .err_noise   (err_noise),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_overrun (err_overrun),
    .rts_n       (rts_n)
);

// File: tb/sim_uart_os_rx.sv
`timescale 1ns/1ps
module sim_uart_os_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_enable = 1'b1;
    logic       cfg_nine_bit = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_rts_en = 1'b1;
    logic       rd_strobe = 1'b0;
    logic       clr_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rxne, err_noise, err_frame, err_parity, err_overrun, rts_n;

    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [8:0] word;
        logic       ne;
        logic       fe;
        logic       pe;
    } exp_t;
    exp_t sb[$];

    uart_os_rx u0 (
        .clk(clk), .rst(rst), .sample_en(sample_en), .rx_in(rx_in),
        .rx_enable(rx_enable), .cfg_nine_bit(cfg_nine_bit),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_rts_en(cfg_rts_en), .rd_strobe(rd_strobe),
        .clr_strobe(clr_strobe), .rx_data(rx_data), .rxne(rxne),
        .err_noise(err_noise), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun), .rts_n(rts_n)
    );

    always #4 clk = ~clk;

    // sample pulse: one clock in four
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            sample_en = 1'b1;
            @(negedge clk);
            sample_en = 1'b0;
        end
    end

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one sample period is exactly four clocks
    task automatic drive_bit(input logic v, input int flip_smp, input int hi_smp);
        for (int k = 1; k <= 16; k++) begin
            rx_in = (k == flip_smp) ? ~v : ((k == hi_smp) ? 1'b1 : v);
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [8:0] w, input logic stop_v,
                              input int flip_pos, input int start_hi,
                              input bit push);
        int   n;
        exp_t e;
        n = cfg_nine_bit ? 9 : 8;
        e.word = cfg_nine_bit ? w : {1'b0, w[7:0]};
        e.ne   = (flip_pos >= 0);
        e.fe   = ~stop_v;
        e.pe   = cfg_par_en && ((^e.word) != cfg_par_odd);
        if (push) sb.push_back(e);
        drive_bit(1'b0, 0, start_hi);
        for (int i = 0; i < n; i++) drive_bit(w[i], (flip_pos == i) ? 9 : 0, 0);
        drive_bit(stop_v, (flip_pos == n) ? 9 : 0, 0);
        drive_bit(1'b1, 0, 0);
        drive_bit(1'b1, 0, 0);
    endtask

    task automatic pulse_rd;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr;
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
        @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && rxne) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected word", 9'h1, 9'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R4 data", rx_data, e.word);
                    check("R3 noise flag with rxne (R7)", {8'h0, err_noise}, {8'h0, e.ne});
                    check("R6 frame flag with rxne (R7)", {8'h0, err_frame}, {8'h0, e.fe});
                    check("R5 parity flag with rxne (R7)", {8'h0, err_parity}, {8'h0, e.pe});
                end
                rd_strobe = 1'b1;
                clr_strobe = 1'b1;
                @(negedge clk);
                rd_strobe = 1'b0;
                clr_strobe = 1'b0;
                check("R11 read clears rxne", {8'h0, rxne}, 9'h0);
                check("R11 clear empties flags",
                      {5'h0, err_noise, err_frame, err_parity, err_overrun}, 9'h0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 rxne", {8'h0, rxne}, 9'h0);
        check("R1 data", rx_data, 9'h0);
        check("R1 flags", {5'h0, err_noise, err_frame, err_parity, err_overrun}, 9'h0);
        check("R1 rts_n", {8'h0, rts_n}, 9'h0);
        repeat (64) @(negedge clk);

        mon_on = 1'b1;
        // R4 8-bit and 9-bit words, LSB first
        send_frame(9'h0A5, 1'b1, -1, 0, 1'b1);
        send_frame(9'h001, 1'b1, -1, 0, 1'b1);
        cfg_nine_bit = 1'b1;
        send_frame(9'h1C3, 1'b1, -1, 0, 1'b1);
        send_frame(9'h100, 1'b1, -1, 0, 1'b1);
        cfg_nine_bit = 1'b0;
        // R3 single disturbed sample on a data bit and on the stop bit
        send_frame(9'h066, 1'b1, 3, 0, 1'b1);
        send_frame(9'h099, 1'b1, 8, 0, 1'b1);
        // R5 parity even/odd, good and bad
        cfg_par_en = 1'b1;
        send_frame(9'h081, 1'b1, -1, 0, 1'b1);
        send_frame(9'h001, 1'b1, -1, 0, 1'b1);
        cfg_par_odd = 1'b1;
        send_frame(9'h001, 1'b1, -1, 0, 1'b1);
        send_frame(9'h003, 1'b1, -1, 0, 1'b1);
        cfg_nine_bit = 1'b1;
        send_frame(9'h1FF, 1'b1, -1, 0, 1'b1);
        send_frame(9'h0FF, 1'b1, -1, 0, 1'b1);
        cfg_nine_bit = 1'b0;
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;
        // R6 low stop bit, data still delivered
        send_frame(9'h03C, 1'b0, -1, 0, 1'b1);
        // R2 high sample at a don't-care start position is accepted
        send_frame(9'h05E, 1'b1, -1, 4, 1'b1);
        repeat (200) @(negedge clk);
        check("R2 all expected words seen", 9'(sb.size()), 9'h0);
        mon_on = 1'b0;

        // R2 high sample at a required-low start position: rejected
        drive_bit(1'b0, 0, 3);
        for (int i = 0; i < 4; i++) drive_bit(1'b1, 0, 0);
        check("R2 bad start no word", {8'h0, rxne}, 9'h0);
        check("R2 bad start no flags",
              {5'h0, err_noise, err_frame, err_parity, err_overrun}, 9'h0);
        // R2 short low pulse of five samples: rejected
        rx_in = 1'b0;
        repeat (20) @(negedge clk);
        rx_in = 1'b1;
        repeat (256) @(negedge clk);
        check("R2 short pulse no word", {8'h0, rxne}, 9'h0);

        // R10 drop enable in the middle of a frame
        drive_bit(1'b0, 0, 0);
        drive_bit(1'b0, 0, 0);
        rx_enable = 1'b0;
        repeat (8) @(negedge clk);
        rx_enable = 1'b1;
        for (int i = 0; i < 7; i++) drive_bit(1'b0, 0, 0);
        for (int i = 0; i < 3; i++) drive_bit(1'b1, 0, 0);
        check("R10 aborted frame no word", {8'h0, rxne}, 9'h0);
        check("R10 aborted frame no flags",
              {5'h0, err_noise, err_frame, err_parity, err_overrun}, 9'h0);

        // R8 / R9 overrun keeps the old word; RTS follows fullness
        send_frame(9'h05A, 1'b1, -1, 0, 1'b0);
        check("R7 word loaded", rx_data, 9'h05A);
        check("R9 rts high while full", {8'h0, rts_n}, 9'h1);
        send_frame(9'h03C, 1'b1, -1, 0, 1'b0);
        check("R8 overrun flag", {8'h0, err_overrun}, 9'h1);
        check("R8 old data kept", rx_data, 9'h05A);
        check("R8 rxne still set", {8'h0, rxne}, 9'h1);
        pulse_rd();
        check("R11 read clears rxne", {8'h0, rxne}, 9'h0);
        check("R11 read keeps overrun", {8'h0, err_overrun}, 9'h1);
        check("R9 rts low when free", {8'h0, rts_n}, 9'h0);
        pulse_clr();
        check("R11 clear drops overrun", {8'h0, err_overrun}, 9'h0);

        // R9 flow control disabled: stays low even when full
        cfg_rts_en = 1'b0;
        send_frame(9'h011, 1'b1, -1, 0, 1'b0);
        check("R9 full word present", {8'h0, rxne}, 9'h1);
        check("R9 rts low when disabled", {8'h0, rts_n}, 9'h0);
        pulse_rd();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule